// File: doc/BRIEF.md
# Rotating-Priority Bus Arbiter for Four PCI Masters

This block decides which of four masters on a shared PCI-style bus owns the bus next. Slot 0 belongs to the on-chip bridge and slots 1 to 3 to off-chip masters. Each master has an active-low request input and an active-low grant output. The arbiter treats the bus as busy whenever FRAME# or IRDY# is low. Priority rotates: the master that most recently started a transaction drops to the lowest rank, and the slot that follows it in the cycle 0, 1, 2, 3, 0 rises to the top.

While the bus is busy the arbiter picks a winner again on every clock, so a grant may move from one master to another. A deasserted grant and a newly asserted one can change on the same edge. While the bus is idle and the granted master is still requesting, the grant is frozen so that master can start. When nobody requests, the grant stays parked where it is.

A strap input, captured only while reset is high, selects the operating mode. With the strap at 1 the internal arbiter drives the grants. With the strap at 0 every internal grant is held inactive. In that mode the bridge's request is forwarded to an external arbiter, and that arbiter's grant is forwarded back to the bridge.

Top module: `pci_rot_arbiter`

## Requirements
- R1: While `rst` is high, with `strap_int_arb`=1, the outputs settle to `gnt_n`=4'b1110 (bridge parked), `ext_req_n`=1 and `bridge_gnt_n`=1. After reset the bridge (bit 0) has the highest priority.
- R2: At most one bit of `gnt_n` is low in any cycle.
- R3: On a re-arbitration, the winner is the first requesting master (a `req_n` bit at 0) after the last-started master in the order 0,1,2,3,0. The last-started master itself ranks lowest. The result appears on `gnt_n` one clock later.
- R4: The last-started master is updated on a clock where `frame_n` is sampled low after being high the clock before. It becomes the master holding the grant at that edge, and the new value takes effect for arbitration from the next clock.
- R5: While the bus is busy (`frame_n`=0 or `irdy_n`=0) and some master requests, the arbiter re-arbitrates every clock. A grant moves away from a holder that has dropped its request.
- R6: While the bus is idle (`frame_n`=1 and `irdy_n`=1) and the granted master keeps its request low, `gnt_n` does not change.
- R7: When no `req_n` bit is low, `gnt_n` keeps its previous value, and the grant stays parked on its holder.
- R8: A grant that changes always moves to a master whose `req_n` was low on the previous clock.
- R9: In external mode (strap 0 at reset), `gnt_n` stays 4'b1111. `ext_req_n` follows `req_n[0]` and `bridge_gnt_n` follows `ext_gnt_n`, each with one clock of delay. In internal mode both of these outputs are held at 1.
- R10: The mode is captured only while `rst` is high, and later changes of `strap_int_arb` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| strap_int_arb | input | 1 | Mode strap: 1 internal arbiter, 0 external arbiter; captured during reset |
| req_n | input | 4 | Active-low requests; bit 0 bridge, bits 1-3 external masters |
| frame_n | input | 1 | Active-low FRAME# observed on the bus |
| irdy_n | input | 1 | Active-low IRDY# observed on the bus |
| gnt_n | output | 4 | Active-low grants, registered; same bit order as req_n |
| ext_req_n | output | 1 | Bridge request forwarded to an external arbiter (external mode) |
| ext_gnt_n | input | 1 | Grant for the bridge from an external arbiter |
| bridge_gnt_n | output | 1 | External arbiter's grant forwarded to the bridge (external mode) |

## Verification
The assertions assume that `strap_int_arb` is stable through each reset pulse and that `req_n`, `frame_n` and `irdy_n` are synchronous to `clk` with no unknown values once reset is released. The idle-hold and parking properties compare `gnt_n` against the request and bus-state inputs of the previous clock, so they assume those inputs change only once per cycle. The directed stimulus changes every input on the falling clock edge and holds it through the next rising edge. It reaches FRAME# falling edges only from a sampled high level, and it keeps each strap change outside or after a full reset pulse.

// File: rtl/pci_arb_pkg.sv
package pci_arb_pkg;
  typedef enum logic {
    ARB_EXTERNAL = 1'b0,
    ARB_INTERNAL = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/pci_arb_rr_pick.sv
module pci_arb_rr_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic          any,
  output logic [IW-1:0] win
);
  // Scan from the farthest slot to the nearest one, so the nearest requester
  // after `last` overwrites the others and wins.
  always_comb begin
    any = |req;
    win = last;
    for (int k = N; k >= 1; k--) begin
      int slot;
      slot = (int'(last) + k) % N;
      if (req[IW'(slot)]) win = IW'(slot);
    end
  end
endmodule

// File: rtl/pci_arb_grant_ctrl.sv
module pci_arb_grant_ctrl
  import pci_arb_pkg::*;
#(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  arb_mode_e     mode_nxt,
  input  logic [N-1:0]  req_n,
  input  logic          frame_n,
  input  logic          irdy_n,
  output logic [N-1:0]  gnt_n_q
);
  logic [IW-1:0] holder_q;
  logic [IW-1:0] last_q;
  logic          frame_q;
  logic          bus_idle;
  logic          keep;
  logic          any_req;
  logic [IW-1:0] winner;
  logic [IW-1:0] holder_nxt;
  logic [N-1:0]  gnt_n_nxt;
  logic          start_seen;

  assign bus_idle   = frame_n & irdy_n;
  assign keep       = bus_idle & ~req_n[holder_q];
  assign start_seen = frame_q & ~frame_n;

  pci_arb_rr_pick #(.N(N)) u_pick (
    .req  (~req_n),
    .last (last_q),
    .any  (any_req),
    .win  (winner)
  );

  assign holder_nxt = (any_req && !keep) ? winner : holder_q;

  for (genvar g = 0; g < N; g++) begin : g_dec
    assign gnt_n_nxt[g] = (mode_nxt == ARB_INTERNAL) ? (holder_nxt != IW'(g)) : 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holder_q <= '0;
      last_q   <= IW'(N - 1);
      frame_q  <= 1'b1;
      gnt_n_q  <= (mode_nxt == ARB_INTERNAL) ? {{(N-1){1'b1}}, 1'b0} : '1;
    end else begin
      holder_q <= holder_nxt;
      frame_q  <= frame_n;
      gnt_n_q  <= gnt_n_nxt;
      if (start_seen) last_q <= holder_q;
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $countones(~gnt_n_q) <= 1);  // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && mode_nxt == ARB_INTERNAL && $past(frame_n && irdy_n)
     && $past(|(~gnt_n_q & ~req_n))) |-> $stable(gnt_n_q));  // R6

  AST_PARK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && mode_nxt == ARB_INTERNAL && $past(&req_n)) |-> $stable(gnt_n_q));  // R7

  AST_GRANT_TO_REQ: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(gnt_n_q)) |-> ((~gnt_n_q & $past(req_n)) == '0));  // R8
endmodule

// File: rtl/pci_rot_arbiter.sv
module pci_rot_arbiter
  import pci_arb_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strap_int_arb,
  input  logic [N-1:0] req_n,
  input  logic         frame_n,
  input  logic         irdy_n,
  output logic [N-1:0] gnt_n,
  output logic         ext_req_n,
  input  logic         ext_gnt_n,
  output logic         bridge_gnt_n
);
  arb_mode_e mode_q;
  arb_mode_e mode_nxt;
  logic      ext_req_q;
  logic      bridge_gnt_q;

  assign mode_nxt = rst ? arb_mode_e'(strap_int_arb) : mode_q;

  always_ff @(posedge clk) begin
    mode_q <= mode_nxt;
    if (rst || mode_nxt == ARB_INTERNAL) begin
      ext_req_q    <= 1'b1;
      bridge_gnt_q <= 1'b1;
    end else begin
      ext_req_q    <= req_n[0];
      bridge_gnt_q <= ext_gnt_n;
    end
  end

  pci_arb_grant_ctrl #(.N(N)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .mode_nxt (mode_nxt),
    .req_n    (req_n),
    .frame_n  (frame_n),
    .irdy_n   (irdy_n),
    .gnt_n_q  (gnt_n)
  );

  assign ext_req_n    = ext_req_q;
  assign bridge_gnt_n = bridge_gnt_q;

  AST_EXT_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && mode_q == ARB_EXTERNAL) |-> (gnt_n == '1));  // R9

  AST_INT_NO_PASS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && mode_q == ARB_INTERNAL) |-> (ext_req_n && bridge_gnt_n));  // R9

  AST_MODE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(mode_q));  // R10
endmodule

// File: tb/pci_rot_arbiter_tb.sv
module pci_rot_arbiter_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       strap_int_arb;
  logic [3:0] req_n;
  logic       frame_n;
  logic       irdy_n;
  logic [3:0] gnt_n;
  logic       ext_req_n;
  logic       ext_gnt_n;
  logic       bridge_gnt_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2 clk = ~clk;

  pci_rot_arbiter #(.N(4)) u_dut (
    .clk           (clk),
    .rst           (rst),
    .strap_int_arb (strap_int_arb),
    .req_n         (req_n),
    .frame_n       (frame_n),
    .irdy_n        (irdy_n),
    .gnt_n         (gnt_n),
    .ext_req_n     (ext_req_n),
    .ext_gnt_n     (ext_gnt_n),
    .bridge_gnt_n  (bridge_gnt_n)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst = 1'b1; strap_int_arb = strap;
    req_n = 4'hF; frame_n = 1'b1; irdy_n = 1'b1; ext_gnt_n = 1'b1;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset(1'b1);
    chk("R1 reset gnt_n", gnt_n, 4'b1110);
    chk("R1 reset ext_req_n", {3'b0, ext_req_n}, 4'b0001);
    chk("R1 reset bridge_gnt_n", {3'b0, bridge_gnt_n}, 4'b0001);
  endtask

  task automatic t_rotation();
    irdy_n = 1'b0; frame_n = 1'b1;          // busy, no FRAME# edge
    req_n = 4'b1100; tick();
    chk("R1 bridge first after reset", gnt_n, 4'b1110);
    req_n = 4'b1101; tick();
    chk("R5 grant moves in busy bus", gnt_n, 4'b1101);
    frame_n = 1'b0; tick();                 // master 1 starts
    chk("R4 holder keeps grant at start", gnt_n, 4'b1101);
    req_n = 4'b0000; tick();
    chk("R3 next after 1 is 2", gnt_n, 4'b1011);
    tick();
    chk("R3 repeat stays 2", gnt_n, 4'b1011);
    frame_n = 1'b1; tick();
    frame_n = 1'b0; tick();                 // master 2 starts
    chk("R4 start by 2 uses old pointer", gnt_n, 4'b1011);
    tick();
    chk("R3 next after 2 is 3", gnt_n, 4'b0111);
    frame_n = 1'b1; tick();
    frame_n = 1'b0; tick();                 // master 3 starts
    tick();
    chk("R3 wrap after 3 is bridge", gnt_n, 4'b1110);
  endtask

  task automatic t_parking();
    req_n = 4'b1111; tick();
    chk("R7 park on bridge busy", gnt_n, 4'b1110);
    frame_n = 1'b1; irdy_n = 1'b1; tick();
    chk("R7 park on bridge idle", gnt_n, 4'b1110);
    frame_n = 1'b1; irdy_n = 1'b0;
    req_n = 4'b1011; tick();
    chk("R8 grant to lone requester 2", gnt_n, 4'b1011);
    req_n = 4'b1111; tick(); tick();
    chk("R7 park on master 2", gnt_n, 4'b1011);
  endtask

  task automatic t_idle_hold();
    frame_n = 1'b1; irdy_n = 1'b1;
    req_n = 4'b0000;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R6 idle grant frozen", gnt_n, 4'b1011);
    end
    req_n = 4'b0100; tick();                // holder 2 drops; pointer is 3
    chk("R6 idle re-arbitrates once holder drops", gnt_n, 4'b1110);
  endtask

  task automatic t_external();
    do_reset(1'b0);
    chk("R9 ext reset gnt_n", gnt_n, 4'b1111);
    irdy_n = 1'b0; req_n = 4'b0000; tick();
    chk("R9 ext gnt_n held high", gnt_n, 4'b1111);
    chk("R9 ext_req_n follows req", {3'b0, ext_req_n}, 4'b0000);
    chk("R9 bridge_gnt_n idle", {3'b0, bridge_gnt_n}, 4'b0001);
    ext_gnt_n = 1'b0; tick();
    chk("R9 bridge_gnt_n follows ext grant", {3'b0, bridge_gnt_n}, 4'b0000);
    strap_int_arb = 1'b1; tick(); tick();
    chk("R10 late strap ignored (ext)", gnt_n, 4'b1111);
    req_n = 4'b1111; tick();
    chk("R9 ext_req_n released", {3'b0, ext_req_n}, 4'b0001);
  endtask

  task automatic t_strap_late_int();
    do_reset(1'b1);
    strap_int_arb = 1'b0;
    irdy_n = 1'b0; req_n = 4'b1101; tick();
    chk("R10 late strap ignored (int)", gnt_n, 4'b1101);
    chk("R10 ext_req_n stays high", {3'b0, ext_req_n}, 4'b0001);
  endtask

  initial begin
    rst = 1'b1; strap_int_arb = 1'b1; req_n = 4'hF;
    frame_n = 1'b1; irdy_n = 1'b1; ext_gnt_n = 1'b1;
    t_reset_state();
    t_rotation();
    t_parking();
    t_idle_hold();
    t_external();
    t_strap_late_int();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule